// File: doc/BRIEF.md
# Interrupt Status Aggregator with Two-Line Routing

This block collects up to 32 interrupt sources from a bus controller core into one sticky status register. A single-cycle event pulse on a source input sets its status bit. The bit stays set until software writes a 1 to that bit position.

Three configuration registers decide how the pending bits reach the two level-sensitive interrupt outputs:
- A per-source mask selects which pending bits may raise an interrupt.
- A per-source route register sends each source to output line 0 or output line 1.
- A two-bit gate switches each output line on or off as a whole.

Software reaches all four registers through a simple single-cycle register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `irq_agg`

## Requirements
- R1: After reset the status, mask, route and line-gate registers read 0, and both bits of `irq_o` are 0.
- R2: When `evt_i[n]` is high at a rising clock edge, status bit n is 1 from that edge onward, and it stays 1 after the pulse ends.
- R3: A write to the status register (address 0) clears every status bit whose `wdata_i` bit is 1. Bits whose `wdata_i` bit is 0 keep their value.
- R4: If an event pulse and a write-1 clear hit the same status bit at the same edge, the bit ends up 1.
- R5: A status bit whose mask bit (address 1) is 0 does not drive either output line. The status bit still latches and can still be read.
- R6: A route bit (address 2) of 0 sends that source to `irq_o[0]`. A route bit of 1 sends it to `irq_o[1]`.
- R7: Bit k of the line-gate register (address 3, bits 1:0) enables `irq_o[k]`. Writing 0 forces both outputs low.
- R8: Register reads return the stored value at the addressed location. The line-gate register reads as its two bits with all upper bits zero.
- R9: Output line k is high exactly when line gate k is 1 and at least one source is pending, unmasked and routed to line k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Event pulses from the core, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 route, 3 line gate |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 2 | Level interrupt lines 0 and 1 |

## Verification
The checker tests the following on every cycle:
- Any event sets its status bit at the next edge, even when a clear hits the same bit.
- A status write with no events removes exactly the bits written as 1.
- With no events and no status write, the status register is unchanged.
- A gated-off line is never high.
- A high line always has a pending, unmasked source behind it.

Only the directed scenarios show the rest:
- Which line each source reaches under a given route setting.
- The read-back values, including the zero-extended line-gate register.
- That a masked source still latches into the status register while both outputs stay quiet.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 2;
  localparam int NLINES = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_ROUTE = 2'd2,
    SEL_GATE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_en_i ? clr_i : '0;

  // set applied after clear: set wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_eff) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int N      = 32,
  parameter int NLINES = 2
) (
  input  logic [N-1:0]      status_i,
  input  logic [N-1:0]      mask_i,
  input  logic [N-1:0]      sel_i,
  input  logic [NLINES-1:0] gate_i,
  output logic [NLINES-1:0] irq_o
);
  logic [N-1:0] live;

  assign live = status_i & mask_i;

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    logic [N-1:0] to_k;
    assign to_k     = (k == 0) ? (live & ~sel_i) : (live & sel_i);
    assign irq_o[k] = gate_i[k] & (|to_k);
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NLINES-1:0] irq_o
);
  logic [NSRC-1:0]   status_q, mask_q, route_q;
  logic [NLINES-1:0] gate_q;
  logic              we_stat, we_mask, we_route, we_gate;

  assign we_stat  = wr_en_i && (addr_i == SEL_STAT);
  assign we_mask  = wr_en_i && (addr_i == SEL_MASK);
  assign we_route = wr_en_i && (addr_i == SEL_ROUTE);
  assign we_gate  = wr_en_i && (addr_i == SEL_GATE);

  irq_sticky #(.N(NSRC)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_i),
    .clr_en_i(we_stat), .clr_i(wdata_i[NSRC-1:0]), .q_o(status_q)
  );

  irq_cfg_reg #(.W(NSRC)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_mask),
    .d_i(wdata_i[NSRC-1:0]), .q_o(mask_q)
  );

  irq_cfg_reg #(.W(NSRC)) u_route (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_route),
    .d_i(wdata_i[NSRC-1:0]), .q_o(route_q)
  );

  irq_cfg_reg #(.W(NLINES)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_gate),
    .d_i(wdata_i[NLINES-1:0]), .q_o(gate_q)
  );

  irq_route #(.N(NSRC), .NLINES(NLINES)) u_route_net (
    .status_i(status_q), .mask_i(mask_q), .sel_i(route_q),
    .gate_i(gate_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      SEL_STAT:  rdata_o[NSRC-1:0]   = status_q;
      SEL_MASK:  rdata_o[NSRC-1:0]   = mask_q;
      SEL_ROUTE: rdata_o[NSRC-1:0]   = route_q;
      SEL_GATE:  rdata_o[NLINES-1:0] = gate_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] evt_i,
  input logic            wr_en_i,
  input logic [1:0]      addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [1:0]      irq_o,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q,
  input logic [1:0]      gate_q
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (addr_i == 2'd0);

  // R2, R4: an event always lands, even against a clear
  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R3: a clear with no events removes exactly the written-1 bits
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !(|evt_i)) |=> (status_q == ($past(status_q) & ~$past(wdata_i[NSRC-1:0]))));

  // R3: no write and no event keeps the status register unchanged
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_wr && !(|evt_i)) |=> $stable(status_q));

  // R7: a gated-off line stays low
  p_gate0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_q[0] |-> !irq_o[0]);
  p_gate1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_q[1] |-> !irq_o[1]);

  // R5: a raised line needs a pending unmasked source
  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|(status_q & mask_q)));
endmodule

bind irq_agg irq_agg_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .status_q(status_q), .mask_q(mask_q), .gate_q(gate_q)
);

// File: tb/irq_agg_test.sv
`timescale 1ns/1ps
module irq_agg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_agg uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(logic [31:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", {30'b0, irq_o}, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(32'h0000_0401);
    @(negedge clk_i);
    rd(2'd0, d);
    chk("R2 sticky", d, 32'h0000_0401);
    chk("R5 masked irq", {30'b0, irq_o}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, d);
    chk("R3 clear one", d, 32'h0000_0400);
    wr(2'd0, 32'h0);
    rd(2'd0, d);
    chk("R3 zero write", d, 32'h0000_0400);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk_i);
    evt_i = 32'h8; wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 32'h0000_0408;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0; wdata_i = '0;
    rd(2'd0, d);
    chk("R4 set wins", d, 32'h0000_0008);
  endtask

  task automatic t_route();
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h3);
    chk("R6 line0", {30'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h8);
    chk("R6 line1", {30'b0, irq_o}, 32'h2);
    wr(2'd3, 32'h1);
    chk("R7 gate1 off", {30'b0, irq_o}, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
    chk("R7 both off", {30'b0, irq_o}, 32'h0);
    wr(2'd3, 32'h3);
    chk("R9 back on", {30'b0, irq_o}, 32'h1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd1, 32'h0);
    chk("R5 masked", {30'b0, irq_o}, 32'h0);
    pulse(32'h0200_0000);
    rd(2'd0, d);
    chk("R5 still latches", d, 32'h0200_0008);
    chk("R5 masked after evt", {30'b0, irq_o}, 32'h0);
    wr(2'd1, 32'h0200_0000);
    wr(2'd2, 32'h0200_0000);
    chk("R9 one source line1", {30'b0, irq_o}, 32'h2);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(2'd2, 32'hA5A5_5A5A);
    rd(2'd2, d);
    chk("R8 route", d, 32'hA5A5_5A5A);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d);
    chk("R8 mask", d, 32'h1234_5678);
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, d);
    chk("R8 gate", d, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R3 clear all", d, 32'h0);
    chk("R9 idle", {30'b0, irq_o}, 32'h0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_route();
    t_mask();
    t_readback();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got hang exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule